// File: doc/BRIEF.md
# Operating-System Tick Countdown Timer

This block is a low-rate countdown timer for periodic operating-system ticks. Software reaches it through a 32-bit register interface with a single access strobe. The interface has three registers: a 24-bit reload value, a read-only view of the live count, and a control word. The control word holds a run bit, an interrupt enable, an autoreload select and a force-restart bit. Counting advances only on a single-cycle tick-enable input, which a slow clock domain or divider outside the block is expected to supply at about 32 kHz.

Starting the timer copies the reload value into the counter. The counter then steps down once per tick. When it expires, the block can emit a one-cycle interrupt pulse. It then either reloads and keeps running, or stops and holds at zero. A request with an illegal width, an unmapped offset or a write to the read-only count register has no effect on state and raises a one-cycle error pulse.

Register offsets are byte offsets: 0x00 holds the reload value, 0x04 the live count and 0x08 the control word. Access width on `acc_size` is encoded as 2'b00 for 8-bit, 2'b01 for 16-bit and 2'b10 for 32-bit.

Top module: `os_tick_timer`

## Requirements
- R1: After reset the reload register reads 0x00FFFFFF, the count reads 0, the control word reads 0x8 (autoreload set, interrupts off, stopped), and no interrupt pulse is produced.
- R2: A 32-bit write to offset 0x00 stores only bits 23:0 of the data, and a read of 0x00 returns the stored value with bits 31:24 zero.
- R3: A read of offset 0x04 returns the current count. A write to 0x04 leaves the count unchanged and pulses `bad_access`.
- R4: A read of offset 0x08 returns autoreload in bit 3, interrupt enable in bit 2 and the run state in bit 0, with every other bit zero.
- R5: Every legal control write updates autoreload (bit 3) and interrupt enable (bit 2) from the written data.
- R6: A control write changes the run state to data bit 0 only when bit 0 differs from the current run state or when bit 1 is written as 1. When this results in running, the count is loaded with the reload value. Any other control write leaves the run state and the count alone.
- R7: While running, each `tick_en` pulse decrements the count by one. The count never changes without a tick or a register write, and ticks have no effect while the timer is stopped or while a control write is taken.
- R8: A tick that arrives while running with a count of 1 (or 0) is an expiry. On an expiry, `irq_pulse` is high for exactly one cycle if interrupts are enabled, and with autoreload set the count is reloaded and the timer keeps running.
- R9: On an expiry with autoreload clear, the run bit is cleared and the count holds at zero through later ticks.
- R10: Any access whose `acc_size` is not 2'b10 changes no register, reads back zero and pulses `bad_access`.
- R11: An access to any offset other than 0x00, 0x04 or 0x08 reads back zero and pulses `bad_access`. Legal accesses leave `bad_access` low.
- R12: `acc_rdata` and `bad_access` take effect in the cycle after the access strobe, and `irq_pulse` in the cycle after the expiring tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe, one request per cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the register |
| acc_size | input | 2 | Access width: 00 byte, 01 half, 10 word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid the cycle after a read |
| tick_en | input | 1 | Single-cycle count enable |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| bad_access | output | 1 | One-cycle illegal-access error |

## Verification
A corrupted count appears on the next read of offset 0x04, one cycle after the strobe. It also shows up as an expiry pulse that arrives one or more ticks early or late. A wrong run, enable or autoreload bit appears in the control readback within one access, and as a missing, extra or repeated interrupt at the next expiry. The bench sweeps small reload values across every autoreload and enable combination, so any of these faults is caught within a few ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam int OFS_RELOAD = 'h00;
    localparam int OFS_COUNT  = 'h04;
    localparam int OFS_CTRL   = 'h08;

    localparam int CTL_RUN   = 0;
    localparam int CTL_FORCE = 1;
    localparam int CTL_IE    = 2;
    localparam int CTL_AR    = 3;

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output reg_sel_e          sel,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              bad
);
    logic width_ok;

    always_comb begin
        width_ok = (acc_size == SIZE_WORD);
        if (acc_addr == ADDR_W'(OFS_RELOAD))     sel = SEL_RELOAD;
        else if (acc_addr == ADDR_W'(OFS_COUNT)) sel = SEL_COUNT;
        else if (acc_addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
        else                                     sel = SEL_NONE;

        bad = 1'b0;
        if (acc_en) begin
            if (!width_ok)                         bad = 1'b1;
            else if (sel == SEL_NONE)              bad = 1'b1;
            else if (acc_we && sel == SEL_COUNT)   bad = 1'b1;
        end
        wr_ok = acc_en && acc_we && !bad;
        rd_ok = acc_en && !acc_we && !bad;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_wdata,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             ar,
    output logic             ie,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             run;
        logic             ar;
        logic             ie;
        logic             irq;
    } core_state_t;

    localparam core_state_t RESET_STATE = '{
        count: '0, run: 1'b0, ar: 1'b1, ie: 1'b0, irq: 1'b0
    };

    core_state_t s_d, s_q;
    logic        last_step;

    always_comb begin
        s_d       = s_q;
        s_d.irq   = 1'b0;
        last_step = (s_q.count <= CNT_W'(1));

        if (ctl_wr) begin
            s_d.ar = ctl_wdata[CTL_AR];
            s_d.ie = ctl_wdata[CTL_IE];
            if ((ctl_wdata[CTL_RUN] != s_q.run) || ctl_wdata[CTL_FORCE]) begin
                s_d.run = ctl_wdata[CTL_RUN];
                if (ctl_wdata[CTL_RUN]) begin
                    s_d.count = reload_val;
                end
            end
        end else if (s_q.run && tick_en) begin
            if (last_step) begin
                s_d.irq = s_q.ie;
                if (s_q.ar) begin
                    s_d.count = reload_val;
                end else begin
                    s_d.count = '0;
                    s_d.run   = 1'b0;
                end
            end else begin
                s_d.count = s_q.count - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign count = s_q.count;
    assign run   = s_q.run;
    assign ar    = s_q.ar;
    assign ie    = s_q.ie;
    assign irq   = s_q.irq;
endmodule

// File: rtl/os_tick_timer.sv
module os_tick_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              tick_en,
    output logic              irq_pulse,
    output logic              bad_access
);
    localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  reload;
        logic [DATA_W-1:0] rdata;
        logic              bad;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     wr_ok, rd_ok, bad_now;
    logic     ctl_wr;

    logic [CNT_W-1:0] count_w;
    logic             run_w, ar_w, ie_w, irq_w;

    tmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .sel      (sel),
        .wr_ok    (wr_ok),
        .rd_ok    (rd_ok),
        .bad      (bad_now)
    );

    assign ctl_wr = wr_ok && (sel == SEL_CTRL);

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (acc_wdata[3:0]),
        .reload_val (r_q.reload),
        .count      (count_w),
        .run        (run_w),
        .ar         (ar_w),
        .ie         (ie_w),
        .irq        (irq_w)
    );

    always_comb begin
        r_d     = r_q;
        r_d.bad = bad_now;

        if (wr_ok && sel == SEL_RELOAD) begin
            r_d.reload = acc_wdata[CNT_W-1:0];
        end

        if (rd_ok) begin
            r_d.rdata = '0;
            case (sel)
                SEL_RELOAD: r_d.rdata[CNT_W-1:0] = r_q.reload;
                SEL_COUNT:  r_d.rdata[CNT_W-1:0] = count_w;
                SEL_CTRL: begin
                    r_d.rdata[CTL_AR]  = ar_w;
                    r_d.rdata[CTL_IE]  = ie_w;
                    r_d.rdata[CTL_RUN] = run_w;
                end
                default:    r_d.rdata = '0;
            endcase
        end else if (acc_en && !acc_we) begin
            r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.reload <= RELOAD_RST;
            r_q.rdata  <= '0;
            r_q.bad    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_rdata  = r_q.rdata;
    assign bad_access = r_q.bad;
    assign irq_pulse  = irq_w;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_en,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              tick_en,
    input logic              irq_pulse,
    input logic              bad_access,
    input logic [CNT_W-1:0]  count,
    input logic              run,
    input logic              ar,
    input logic              ie
);
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(ie));

    assert_expiry_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && count <= CNT_W'(1) && ie && !acc_en) |=> irq_pulse);

    assert_oneshot_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_en && count <= CNT_W'(1) && !ar && !acc_en) |=> (!run && count == '0));

    assert_count_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(acc_en && acc_we)) |=> $stable(count));

    assert_count_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && acc_addr == ADDR_W'(4) && acc_size == 2'b10 && !tick_en)
        |=> ($stable(count) && bad_access));

    assert_bad_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_size != 2'b10) |=> (bad_access && ($past(acc_we) || acc_rdata == '0)));
endmodule

bind os_tick_timer tmr_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_tmr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_we     (acc_we),
    .acc_addr   (acc_addr),
    .acc_size   (acc_size),
    .acc_rdata  (acc_rdata),
    .tick_en    (tick_en),
    .irq_pulse  (irq_pulse),
    .bad_access (bad_access),
    .count      (count_w),
    .run        (run_w),
    .ar         (ar_w),
    .ie         (ie_w)
);

// File: tb/os_tick_timer_tb_top.sv
module os_tick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [1:0]  acc_size = 2'b10;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        tick_en = 1'b0;
    logic        irq_pulse;
    logic        bad_access;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;
    logic [31:0] rd_val;
    logic        rd_bad;
    logic        got_irq;

    always #2.5 clk = ~clk;

    os_tick_timer dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .tick_en(tick_en), .irq_pulse(irq_pulse),
        .bad_access(bad_access)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog: got timeout expected completion");
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [1:0] sz);
        @(negedge clk);
        acc_en = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d; acc_size = sz;
        @(negedge clk);
        rd_val = acc_rdata; rd_bad = bad_access;
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        acc(1'b1, a, d, 2'b10);
    endtask

    task automatic rd(input logic [7:0] a);
        acc(1'b0, a, 32'h0, 2'b10);
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        got_irq = irq_pulse;
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq_pulse}, 32'h0);
        rd(8'h00); chk("R1 reload", rd_val, 32'h00FF_FFFF);
        rd(8'h04); chk("R1 count", rd_val, 32'h0);
        rd(8'h08); chk("R1 ctrl", rd_val, 32'h8);
        chk("R11 legal read no error", {31'b0, rd_bad}, 32'h0);

        // R2 masking
        wr(8'h00, 32'hABCD_EF12);
        rd(8'h00); chk("R2 reload mask", rd_val, 32'h00CD_EF12);

        // R3 count is read-only
        wr(8'h04, 32'h0000_0055); chk("R3 write bad", {31'b0, rd_bad}, 32'h1);
        rd(8'h04); chk("R3 count unchanged", rd_val, 32'h0);

        // R4/R5 control fields
        wr(8'h08, 32'hFFFF_FFF4);
        rd(8'h08); chk("R4 R5 ctrl ie only", rd_val, 32'h4);

        // R7/R8/R9 sweep over reload, autoreload and enable
        for (int ar = 0; ar < 2; ar++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int rl = 1; rl <= 5; rl++) begin
                    wr(8'h00, 32'(rl));
                    wr(8'h08, 32'((ar << 3) | (ie << 2) | 1));
                    rd(8'h04); chk("R6 start loads reload", rd_val, 32'(rl));
                    for (int k = 1; k <= rl; k++) begin
                        tick();
                        chk("R8 irq timing", {31'b0, got_irq}, 32'((k == rl) && (ie == 1)));
                        rd(8'h04);
                        if (k < rl)      chk("R7 decrement", rd_val, 32'(rl - k));
                        else if (ar == 1) chk("R8 autoreload", rd_val, 32'(rl));
                        else             chk("R9 hold zero", rd_val, 32'h0);
                        rd(8'h08);
                        chk("R9 run state", {31'b0, rd_val[0]}, 32'((ar == 1) || (k < rl)));
                    end
                    if (ar == 0) begin
                        tick();
                        chk("R9 no irq when stopped", {31'b0, got_irq}, 32'h0);
                        rd(8'h04); chk("R9 stays zero", rd_val, 32'h0);
                    end else begin
                        wr(8'h08, 32'((ar << 3) | (ie << 2)));
                        rd(8'h08); chk("R6 stop", {31'b0, rd_val[0]}, 32'h0);
                    end
                end
            end
        end

        // R6 restart rules
        wr(8'h00, 32'd10);
        wr(8'h08, 32'h1);
        tick(); tick(); tick();
        rd(8'h04); chk("R7 after three ticks", rd_val, 32'd7);
        wr(8'h08, 32'h1);
        rd(8'h04); chk("R6 same run no restart", rd_val, 32'd7);
        wr(8'h08, 32'h3);
        rd(8'h04); chk("R6 force restart", rd_val, 32'd10);
        repeat (6) @(negedge clk);
        rd(8'h04); chk("R7 no tick no change", rd_val, 32'd10);
        wr(8'h08, 32'h0);
        tick();
        rd(8'h04); chk("R7 stopped ignores tick", rd_val, 32'd10);
        wr(8'h08, 32'h2);
        rd(8'h08); chk("R6 force with run 0 stays stopped", rd_val, 32'h0);

        // R10 bad width
        acc(1'b1, 8'h00, 32'h0000_1234, 2'b01);
        chk("R10 half write bad", {31'b0, rd_bad}, 32'h1);
        rd(8'h00); chk("R10 reload unchanged", rd_val, 32'd10);
        acc(1'b0, 8'h00, 32'h0, 2'b00);
        chk("R10 byte read bad", {31'b0, rd_bad}, 32'h1);
        chk("R10 byte read zero", rd_val, 32'h0);
        acc(1'b1, 8'h08, 32'h0000_0001, 2'b00);
        rd(8'h08); chk("R10 ctrl unchanged", rd_val, 32'h0);

        // R11 bad offset
        rd(8'h0C); chk("R11 unmapped zero", rd_val, 32'h0);
        chk("R11 unmapped bad", {31'b0, rd_bad}, 32'h1);
        rd(8'h02); chk("R11 misaligned bad", {31'b0, rd_bad}, 32'h1);
        rd(8'h00); chk("R11 legal no error", {31'b0, rd_bad}, 32'h0);
        chk("R12 read data next cycle", rd_val, 32'd10);

        summary();
    end
endmodule